// File: doc/BRIEF.md
# Synchronous Processor Bus Register Slave

This block lets a host processor reach a small internal file of 8-bit registers over a clocked bus. At every rising edge of the bus clock it samples the select, read/write, write strobe, data strobe, data-enable, address and write-data inputs. It then runs a short state machine that adds a fixed number of wait states and raises a single-cycle ready pulse when the access may end. The host holds its strobes until it samples ready high, and only then moves on to the next access.

A write takes effect at the clock edge where the slave raises ready, and only if the select, read/write and write strobes are all sampled low at that edge. A read loads the addressed register into a registered output and raises an output enable while the access is in progress. The enable is given only when the host asserts its data-enable input. Ready, read data and the enable all change only at rising clock edges.

The state machine has four states. IDLE waits for an access. WAIT counts wait states. DONE is the one cycle with ready high. TAIL waits for the host to release select. Its transitions are:
- start (IDLE→WAIT, or IDLE→DONE when no wait states are configured)
- finish (WAIT→DONE)
- abort (WAIT→IDLE when select rises)
- release (DONE or TAIL→IDLE when select is high)
- linger (DONE→TAIL while select is still low)

Top module: `pbus_slave`

## Requirements
- R1: While the synchronous active-high reset is applied, and immediately after it is released, `rdy`, `rdata_oe` and `rdata` are 0 and every register holds 0.
- R2: A write is recognised when `sel_n`=0, `rd_wrn`=0 and `wstb_n`=0 are sampled together. `wdata` is stored into register `addr[IDX_W-1:0]` at the same edge that raises `rdy`.
- R3: For every access, `rdy` is high for exactly one clock. It first reads high NWAIT+1 rising edges after the edge at which the access strobes were first sampled active.
- R4: A read is recognised when `sel_n`=0, `rd_wrn`=1 and `dstb_n`=0 are sampled together. `rdata` holds the addressed register's value during the cycle in which `rdy` is high.
- R5: `rdata_oe` is high only while a read is in WAIT or DONE and `den_n` was sampled low. It stays low for writes, and it stays low for reads made with `den_n`=1.
- R6: If any address bit at or above IDX_W is 1, the access still completes with `rdy`, but a write changes no register and a read returns 0.
- R7: If `sel_n` is sampled high before `rdy` is raised, the access is aborted. No register changes, `rdy` stays low, and the slave returns to IDLE.
- R8: After `rdy`, no new access is accepted until `sel_n` has been sampled high. Holding the strobes low produces no second `rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low slave select |
| rd_wrn | input | 1 | 1 = read, 0 = write |
| wstb_n | input | 1 | Active-low write strobe |
| dstb_n | input | 1 | Active-low data strobe that qualifies reads |
| den_n | input | 1 | Active-low data-enable from the host; gates `rdata_oe` |
| addr | input | 15 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Output enable for `rdata` |
| rdy | output | 1 | Active-high ready; one clock per completed access |

## Verification
Every register index is written with an arithmetic pattern, read back, and then overwritten with a second, XOR-derived pattern. This separates correct index decoding from aliasing or stuck bits. Each access is timed from strobe to ready, so the wait-state count and the single-cycle pulse are measured and not assumed.

Addresses with a single high bit set, one position at a time, confirm that out-of-range writes leave the file untouched. An access aborted mid-wait, and an access whose strobes are held past ready, show that neither path writes data or produces a spurious ready. Reads made with the data-enable inactive show that the output enable follows that input and not the read alone.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE,
        ST_TAIL
    } bus_state_e;
endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 3
) (
    input  logic              sel_n,
    input  logic              rd_wrn,
    input  logic              wstb_n,
    input  logic              dstb_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_req,
    output logic              rd_req,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_W = ADDR_W - IDX_W;

    always_comb begin
        wr_req = !sel_n && !rd_wrn && !wstb_n;
        rd_req = !sel_n &&  rd_wrn && !dstb_n;
        idx    = addr[IDX_W-1:0];
        hit    = (addr[ADDR_W-1:IDX_W] == {HI_W{1'b0}});
    end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG = 1 << IDX_W;

    logic [NREG-1:0][DATA_W-1:0] mem;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[ridx];

    // R7
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));
endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NWAIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              den_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_val,
    output logic              commit,
    output logic              rdy,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = (NWAIT > 1) ? $clog2(NWAIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'((NWAIT > 0) ? NWAIT - 1 : 0);

    bus_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             kind_q, kind_d;
    logic             fire;
    logic             still_on;

    assign still_on = kind_q ? rd_req : wr_req;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        kind_d  = kind_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req || rd_req) begin
                    kind_d = rd_req;
                    cnt_d  = '0;
                    if (NWAIT == 0) begin
                        state_d = ST_DONE;
                        fire    = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (sel_n) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == LAST) begin
                    if (still_on) begin
                        state_d = ST_DONE;
                        fire    = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = sel_n ? ST_IDLE : ST_TAIL;
            end
            ST_TAIL: begin
                if (sel_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign commit = fire && !kind_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kind_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy   <= 1'b0;
            oe    <= 1'b0;
            rdata <= '0;
        end else begin
            rdy <= fire;
            oe  <= ((state_d == ST_WAIT) || (state_d == ST_DONE)) && kind_d && !den_n;
            if (fire && kind_d) begin
                rdata <= rd_val;
            end
        end
    end

    // R3
    rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && sel_n) |=> (state_q == ST_IDLE && !rdy));

    // R8
    rdy_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> $past(!sel_n));

    // R5
    oe_den_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> $past(!den_n));
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int NWAIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_wrn,
    input  logic              wstb_n,
    input  logic              dstb_n,
    input  logic              den_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              rdy
);
    logic              wr_req, rd_req, hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] file_q;
    logic [DATA_W-1:0] rd_val;
    logic              commit;
    logic              file_we;

    pbus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .sel_n  (sel_n),
        .rd_wrn (rd_wrn),
        .wstb_n (wstb_n),
        .dstb_n (dstb_n),
        .addr   (addr),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .hit    (hit),
        .idx    (idx)
    );

    assign file_we = commit && hit;
    assign rd_val  = hit ? file_q : '0;

    pbus_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (file_we),
        .widx  (idx),
        .wdata (wdata),
        .ridx  (idx),
        .rdata (file_q)
    );

    pbus_fsm #(.DATA_W(DATA_W), .NWAIT(NWAIT)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .den_n  (den_n),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .rd_val (rd_val),
        .commit (commit),
        .rdy    (rdy),
        .oe     (rdata_oe),
        .rdata  (rdata)
    );

    // R2
    commit_with_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> rdy);
endmodule

// File: tb/sim_pbus_slave.sv
module sim_pbus_slave;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;
    localparam int NWAIT  = 1;
    localparam int NREG   = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_n = 1'b1, rd_wrn = 1'b1, wstb_n = 1'b1, dstb_n = 1'b1, den_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe, rdy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pbus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .NWAIT(NWAIT)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_wrn(rd_wrn), .wstb_n(wstb_n),
        .dstb_n(dstb_n), .den_n(den_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_a(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    // One access: returns latency to rdy, data while rdy, whether oe was seen
    task automatic access(input bit rd, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          input bit den, input int hold,
                          output int lat, output logic [7:0] got, output bit oe_seen);
        lat = 0; got = '0; oe_seen = 1'b0;
        @(negedge clk);
        sel_n = 1'b0; rd_wrn = rd; wstb_n = rd; dstb_n = !rd; den_n = den;
        addr = a; wdata = d;
        for (int n = 1; n <= 50; n++) begin
            @(negedge clk);
            oe_seen |= rdata_oe;
            if (rdy) begin
                lat = n; got = rdata;
                break;
            end
        end
        if (lat == 0) chk(1'b0, "R3 rdy timeout", 0, NWAIT + 1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(!rdy, "R8 no second rdy while held", int'(rdy), 0);
        end
        sel_n = 1'b1; wstb_n = 1'b1; dstb_n = 1'b1; den_n = 1'b1;
        @(negedge clk);
        chk(!rdy, "R3 rdy one cycle", int'(rdy), 0);
        chk(!rdata_oe, "R5 oe drops after access", int'(rdata_oe), 0);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        int lat; logic [7:0] g; bit oe;
        access(1'b0, a, d, 1'b0, 0, lat, g, oe);
        chk(lat == NWAIT + 1, "R3 write latency", lat, NWAIT + 1);
        chk(!oe, "R5 no oe on write", int'(oe), 0);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
        int lat; logic [7:0] g; bit oe;
        access(1'b1, a, 8'h00, 1'b0, 0, lat, g, oe);
        chk(lat == NWAIT + 1, "R3 read latency", lat, NWAIT + 1);
        chk(g == exp, req, int'(g), int'(exp));
        chk(oe, "R5 oe during read", int'(oe), 1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat; logic [7:0] g; bit oe;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rdy && !rdata_oe && rdata == 0, "R1 outputs in reset", int'(rdata), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rdy && !rdata_oe && rdata == 0, "R1 outputs after reset", int'(rdata), 0);
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i), 8'h00, "R1 register cleared");

        // R2 R4 sweep with two patterns
        for (int i = 0; i < NREG; i++) do_write(ADDR_W'(i), pat_a(i));
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i), pat_a(i), "R4 read pattern A");
        for (int i = 0; i < NREG; i++) do_write(ADDR_W'(i), pat_a(i) ^ 8'hA5);
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i), pat_a(i) ^ 8'hA5, "R2 overwrite pattern B");

        // R5 read with data-enable inactive
        for (int i = 0; i < NREG; i++) begin
            access(1'b1, ADDR_W'(i), 8'h00, 1'b1, 0, lat, g, oe);
            chk(!oe, "R5 oe low with den_n high", int'(oe), 0);
            chk(g == (pat_a(i) ^ 8'hA5), "R4 data with den_n high", int'(g), int'(pat_a(i) ^ 8'hA5));
        end

        // R6 out-of-range addresses, one high bit at a time
        for (int k = IDX_W; k < ADDR_W; k++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(1) << k;
            a[IDX_W-1:0] = IDX_W'(k);
            access(1'b0, a, 8'hEE, 1'b0, 0, lat, g, oe);
            chk(lat == NWAIT + 1, "R6 out-of-range write completes", lat, NWAIT + 1);
            access(1'b1, a, 8'h00, 1'b0, 0, lat, g, oe);
            chk(g == 8'h00, "R6 out-of-range read zero", int'(g), 0);
        end
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i), pat_a(i) ^ 8'hA5, "R6 file untouched");

        // R7 abort mid-wait
        @(negedge clk);
        sel_n = 1'b0; rd_wrn = 1'b0; wstb_n = 1'b0; addr = ADDR_W'(2); wdata = 8'h3C;
        @(negedge clk);
        sel_n = 1'b1; wstb_n = 1'b1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(!rdy, "R7 no rdy after abort", int'(rdy), 0);
        end
        do_read(ADDR_W'(2), pat_a(2) ^ 8'hA5, "R7 aborted write ignored");

        // R8 strobes held past rdy
        access(1'b0, ADDR_W'(5), 8'h77, 1'b0, 4, lat, g, oe);
        chk(lat == NWAIT + 1, "R8 held write latency", lat, NWAIT + 1);
        do_read(ADDR_W'(5), 8'h77, "R8 held write stored");
        access(1'b1, ADDR_W'(5), 8'h00, 1'b0, 3, lat, g, oe);
        chk(g == 8'h77, "R8 held read data", int'(g), 8'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule